// File: doc/BRIEF.md
# GPIO Controller with Single Selectable Interrupt Source

This block gives a processor register-level control over 22 general-purpose pins. Software picks each pin's direction and output level through two registers, and it reads every pin's level through a third register. Pad inputs pass through a two-flop synchroniser before software or the interrupt logic sees them. Output pins drive their pad from the output-data register and raise their pad enable from the direction register.

The interrupt path does not use per-pin enables. One 8-bit configuration word names a single pin and a trigger mode, and the block drives one interrupt line from that pin alone. The modes are: disabled, active while the pin is low, active while the pin is high, and any-edge. An edge event is held until software rewrites the configuration word. A pin that is driven as an output, or a pin number that does not exist, never raises the line.

Top module: `gpio_selirq`

## Requirements
- R1: Registers are chosen by busAddr[4:3]: 0 = input data (offset 0x00), 1 = output data (0x08), 2 = direction (0x10), 3 = interrupt configuration (0x18). A write takes effect when busSel and busWr are both high at a rising clock edge. busRdata is a combinational function of busAddr. Bits above 21 of the data and direction registers read as 0, and so do bits above 7 of the configuration register, whatever was written to them.
- R2: padOut[n] equals bit n of the output-data register. padOe[n] equals bit n of the direction register, where 1 means output.
- R3: Bit n of the input-data register gives the level of padIn[n] after two rising clock edges of synchronisation, whatever the pin's direction.
- R4: Configuration bits [5:0] give the source pin number. Bits [7:6] give the trigger: 0 off, 1 low level, 2 high level, 3 edge.
- R5: In off mode irqOut is 0.
- R6: In the low and high level modes, irqOut follows the synchronised level of the selected pin without latching. It is 1 while the level matches the mode.
- R7: In edge mode, any rising or falling change of the selected pin's synchronised level sets irqOut. irqOut stays 1 until the configuration register is written.
- R8: If the selected pin's direction bit is 1, irqOut is 0.
- R9: A selected pin number of 22 or higher selects no pin, and irqOut is 0.
- R10: After reset the output-data, direction and configuration registers are all 0.
- R11: A write to the input-data register changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write strobe (valid with busSel) |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| padIn | input | 22 | Asynchronous pad levels |
| padOut | output | 22 | Pad output levels |
| padOe | output | 22 | Pad output enables |
| irqOut | output | 1 | Interrupt line |

## Verification
A table of configurations drives each trigger mode with the selected pin at both levels. It also repeats the level modes on the lowest and highest valid pins, on an output pin and on out-of-range numbers, which separates a correct pin decode and direction gate from a design that only checks the mode. Edge mode is tried with a rising change and then a falling change, and each is followed by idle cycles and a configuration rewrite. This separates a latched any-edge detector from a rising-only one and from a level follower. An alternating pad pattern is sampled one and two edges after it changes, which pins the synchroniser depth. Writes of all-ones show which register bits are unused.

// File: rtl/gpio_selirq_pkg.sv
package gpio_selirq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_EDGE = 2'd3
  } trigMode_e;

  typedef enum logic [1:0] {
    REG_IN  = 2'd0,
    REG_OUT = 2'd1,
    REG_DIR = 2'd2,
    REG_CFG = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrOut;
    logic    wrDir;
    logic    wrCfg;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_selirq_ctrl.sv
module gpio_selirq_ctrl
  import gpio_selirq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int IDX_LSB = 3
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  localparam int IDX_MSB = IDX_LSB + 1;

  regSel_e regIdx;
  logic    wrEn;

  assign regIdx = regSel_e'(busAddr[IDX_MSB:IDX_LSB]);
  assign wrEn   = busSel && busWr;

  always_comb begin
    strobe       = '0;
    strobe.rdSel = regIdx;
    if (wrEn) begin
      unique case (regIdx)
        REG_OUT: strobe.wrOut = 1'b1;
        REG_DIR: strobe.wrDir = 1'b1;
        REG_CFG: strobe.wrCfg = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_selirq_dp.sv
module gpio_selirq_dp
  import gpio_selirq_pkg::*;
#(
  parameter int PIN_N       = 22,
  parameter int DATA_W      = 32,
  parameter int SEL_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [PIN_N-1:0]  padIn,
  output logic [PIN_N-1:0]  padOut,
  output logic [PIN_N-1:0]  padOe,
  output logic              irqOut
);

  localparam int CFG_W = SEL_W + 2;

  logic [PIN_N-1:0] outReg;
  logic [PIN_N-1:0] dirReg;
  logic [CFG_W-1:0] cfgReg;
  logic [PIN_N-1:0] syncStage [SYNC_STAGES];
  logic [PIN_N-1:0] inData;
  logic [PIN_N-1:0] prevData;
  logic             edgeHeld;

  logic [SEL_W-1:0] pinSel;
  trigMode_e        trigMode;
  logic             selHit;
  logic             selLevel;
  logic             selPrev;
  logic             selIsOut;
  logic             selActive;
  logic             edgeNow;

  // Input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= padIn;
  end

  genvar gs;
  generate
    for (gs = 1; gs < SYNC_STAGES; gs++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[gs] <= '0;
        else       syncStage[gs] <= syncStage[gs-1];
      end
    end
  endgenerate

  assign inData = syncStage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevData <= '0;
    else       prevData <= inData;
  end

  // Software registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      dirReg <= '0;
      cfgReg <= '0;
    end else begin
      if (strobe.wrOut) outReg <= wrData[PIN_N-1:0];
      if (strobe.wrDir) dirReg <= wrData[PIN_N-1:0];
      if (strobe.wrCfg) cfgReg <= wrData[CFG_W-1:0];
    end
  end

  assign padOut = outReg;
  assign padOe  = dirReg;

  // Source pin selection
  assign pinSel   = cfgReg[SEL_W-1:0];
  assign trigMode = trigMode_e'(cfgReg[CFG_W-1:SEL_W]);

  always_comb begin
    selHit   = 1'b0;
    selLevel = 1'b0;
    selPrev  = 1'b0;
    selIsOut = 1'b0;
    for (int i = 0; i < PIN_N; i++) begin
      if (pinSel == SEL_W'(i)) begin
        selHit   = 1'b1;
        selLevel = inData[i];
        selPrev  = prevData[i];
        selIsOut = dirReg[i];
      end
    end
  end

  assign selActive = selHit && !selIsOut;
  assign edgeNow   = selActive && (trigMode == TRIG_EDGE) && (selLevel != selPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              edgeHeld <= 1'b0;
    else if (strobe.wrCfg)  edgeHeld <= 1'b0;
    else if (edgeNow)       edgeHeld <= 1'b1;
  end

  always_comb begin
    irqOut = 1'b0;
    if (selActive) begin
      unique case (trigMode)
        TRIG_LOW:  irqOut = !selLevel;
        TRIG_HIGH: irqOut = selLevel;
        TRIG_EDGE: irqOut = edgeHeld;
        default:   irqOut = 1'b0;
      endcase
    end
  end

  // Read mux
  always_comb begin
    unique case (strobe.rdSel)
      REG_IN:  rdData = DATA_W'(inData);
      REG_OUT: rdData = DATA_W'(outReg);
      REG_DIR: rdData = DATA_W'(dirReg);
      default: rdData = DATA_W'(cfgReg);
    endcase
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[CFG_W-1:SEL_W] == 2'd0) |-> !irqOut); // R5

  AST_OUTPUT_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (selHit && padOe[pinSel[$clog2(PIN_N)-1:0]]) |-> !irqOut); // R8

  AST_RANGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pinSel) >= PIN_N) |-> !irqOut); // R9

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (trigMode == TRIG_EDGE && irqOut && !strobe.wrCfg && !strobe.wrDir) |=> irqOut); // R7

  AST_CFG_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCfg && wrData[CFG_W-1:SEL_W] == 2'd3) |=> !irqOut); // R7

endmodule

// File: rtl/gpio_selirq.sv
module gpio_selirq
  import gpio_selirq_pkg::*;
#(
  parameter int PIN_N  = 22,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PIN_N-1:0]  padIn,
  output logic [PIN_N-1:0]  padOut,
  output logic [PIN_N-1:0]  padOe,
  output logic              irqOut
);

  ctrlStrobe_t strobe;

  gpio_selirq_ctrl #(
    .ADDR_W (ADDR_W),
    .IDX_LSB(3)
  ) uCtrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpio_selirq_dp #(
    .PIN_N      (PIN_N),
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W),
    .SYNC_STAGES(2)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(busWdata),
    .rdData(busRdata),
    .padIn (padIn),
    .padOut(padOut),
    .padOe (padOe),
    .irqOut(irqOut)
  );

endmodule

// File: tb/gpio_selirq_test.sv
module gpio_selirq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [21:0] padIn = '0;
  logic [21:0] padOut;
  logic [21:0] padOe;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_selirq uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [5:0] pin;
    logic       lvl;
    logic       asOut;
    logic       exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 6'd3,  1'b1, 1'b0, 1'b0},  // R5 off
    '{2'd1, 6'd3,  1'b0, 1'b0, 1'b1},  // R6 low, level low
    '{2'd1, 6'd3,  1'b1, 1'b0, 1'b0},  // R6 low, level high
    '{2'd2, 6'd3,  1'b1, 1'b0, 1'b1},  // R6 high, level high
    '{2'd2, 6'd3,  1'b0, 1'b0, 1'b0},  // R6 high, level low
    '{2'd2, 6'd21, 1'b1, 1'b0, 1'b1},  // R4 top pin
    '{2'd1, 6'd0,  1'b0, 1'b0, 1'b1},  // R4 bottom pin
    '{2'd2, 6'd21, 1'b1, 1'b1, 1'b0},  // R8 output pin
    '{2'd1, 6'd0,  1'b0, 1'b1, 1'b0},  // R8 output pin
    '{2'd1, 6'd22, 1'b0, 1'b0, 1'b0},  // R9 pin 22
    '{2'd2, 6'd63, 1'b1, 1'b0, 1'b0}   // R9 pin 63
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1;
    data = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R10 reset state
    busRead(5'h08, rd); check("R10 out reg", rd, 32'h0);
    busRead(5'h10, rd); check("R10 dir reg", rd, 32'h0);
    busRead(5'h18, rd); check("R10 cfg reg", rd, 32'h0);
    check("R10 irq", {31'b0, irqOut}, 32'h0);
    check("R10 padOe", {10'b0, padOe}, 32'h0);

    // R1 unused bits, R2 pad drive
    busWrite(5'h08, 32'hFFFF_FFFF);
    busRead(5'h08, rd); check("R1 out width", rd, 32'h003F_FFFF);
    busWrite(5'h08, 32'h0012_3456);
    busRead(5'h08, rd); check("R1 out read", rd, 32'h0012_3456);
    check("R2 padOut", {10'b0, padOut}, 32'h0012_3456);
    busWrite(5'h10, 32'hFFC2_1A5B);
    busRead(5'h10, rd); check("R1 dir read", rd, 32'h0002_1A5B);
    check("R2 padOe", {10'b0, padOe}, 32'h0002_1A5B);
    busWrite(5'h18, 32'hFFFF_FF80);
    busRead(5'h18, rd); check("R1 cfg width", rd, 32'h0000_0080);

    // R3 synchroniser latency, direction independent
    busWrite(5'h10, 32'h003F_FFFF);
    @(negedge clk);
    padIn = 22'h2A_AAAA;
    @(negedge clk);
    busRead(5'h00, rd); check("R3 one edge", rd, 32'h0);
    @(negedge clk);
    busRead(5'h00, rd); check("R3 two edges", rd, 32'h002A_AAAA);

    // R11 write to input register ignored
    busWrite(5'h00, 32'h0015_5555);
    busRead(5'h00, rd); check("R11 in reg", rd, 32'h002A_AAAA);
    busRead(5'h08, rd); check("R11 out reg", rd, 32'h0012_3456);
    check("R11 padOut", {10'b0, padOut}, 32'h0012_3456);
    check("R11 padOe", {10'b0, padOe}, 32'h003F_FFFF);

    // R4 R5 R6 R8 R9 table
    for (int v = 0; v < NVEC; v++) begin
      padIn = {22{VECS[v].lvl}};
      busWrite(5'h10, VECS[v].asOut ? 32'h003F_FFFF : 32'h0);
      busWrite(5'h18, {24'b0, VECS[v].mode, VECS[v].pin});
      idle(2);
      check($sformatf("R4 R6 R8 R9 vector %0d", v), {31'b0, irqOut}, {31'b0, VECS[v].exp});
    end

    // R6 level follows without latching
    busWrite(5'h10, 32'h0);
    padIn = 22'h0;
    busWrite(5'h18, {24'b0, 2'd2, 6'd5});
    idle(3);
    padIn[5] = 1'b1;
    idle(3);
    check("R6 high follows", {31'b0, irqOut}, 32'h1);
    padIn[5] = 1'b0;
    idle(3);
    check("R6 no latch", {31'b0, irqOut}, 32'h0);

    // R7 edge mode
    busWrite(5'h18, {24'b0, 2'd3, 6'd7});
    idle(4);
    check("R7 no edge", {31'b0, irqOut}, 32'h0);
    padIn[6] = 1'b1;
    idle(4);
    check("R7 other pin", {31'b0, irqOut}, 32'h0);
    padIn[7] = 1'b1;
    idle(4);
    check("R7 rising", {31'b0, irqOut}, 32'h1);
    idle(6);
    check("R7 held", {31'b0, irqOut}, 32'h1);
    busWrite(5'h18, {24'b0, 2'd3, 6'd7});
    check("R7 cleared", {31'b0, irqOut}, 32'h0);
    idle(3);
    check("R7 stays clear", {31'b0, irqOut}, 32'h0);
    padIn[7] = 1'b0;
    idle(4);
    check("R7 falling", {31'b0, irqOut}, 32'h1);
    busWrite(5'h10, 32'h0000_0080);
    check("R8 edge on output", {31'b0, irqOut}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule